// File: doc/BRIEF.md
# TMDS Channel Symbol Decoder with Word Alignment

This block sits on the receive side of one colour channel of a transition-minimised differential video link. After an external deserializer, it takes one 10-bit raw word on every pixel clock. It finds where the symbol boundary falls inside the word stream. Each aligned symbol then becomes one of two things: an 8-bit pixel byte with data enable high, or a control code with data enable low. When the block serves the blue channel, control bit 0 carries horizontal sync and control bit 1 carries vertical sync. On the other two colour channels both control bits arrive as zero.

Alignment works by searching. The block joins the current raw word to the previous one and cuts a 10-bit slice out of the joined value at a bit offset. If no control token shows up at that offset for a programmable number of clocks, the offset moves on by one. A run of consecutive tokens at the same offset raises a lock flag. A full search interval without any token drops the lock.

Top module: `tmds_symbol_decoder`

## Requirements
- R1: When the aligned symbol is a control token, data enable goes low and the control output shows the token's code {c1,c0}. The tokens are 10'b1101010100 for code 00, 10'b0010101011 for 01, 10'b0101010100 for 10 and 10'b1010101011 for 11.
- R2: Any other symbol drives data enable high, and the pixel byte is recovered as follows. If bit 9 is 1, bits 7..0 are inverted first. Output bit 0 equals the resulting bit 0. Each output bit k from 1 to 7 is the XOR of resulting bits k and k-1 when bit 8 is 1, and their XNOR when bit 8 is 0.
- R3: At offset 0, a word sampled at clock edge N appears on the pixel, data-enable and control outputs right after edge N+1. That is two register stages in all, and the three outputs always stay aligned with each other.
- R4: Across data symbols the control output keeps the code of the most recent token. While a token is being shown, the pixel output is zero.
- R5: If SEARCH_CYCLES consecutive aligned slices contain no control token, the offset advances by one. From 9 it wraps to 0.
- R6: At offset o, the aligned symbol is bits o+9..o of {current word, previous word}. Bit 0 of each word is the earliest bit on the wire.
- R7: The lock flag rises on the LOCK_RUN-th consecutive token at the current offset. Any non-token slice restarts the count.
- R8: The lock flag clears when the search interval expires without a token.
- R9: A synchronous active-high reset sets the offset to 0 and clears the lock flag, data enable, the control output and the pixel output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | 10 | Raw deserialized word, bit 0 earliest |
| pix_out | output | 8 | Recovered pixel byte |
| de_out | output | 1 | Data enable, low during blanking tokens |
| ctl_out | output | 2 | Control code {c1,c0}; on blue, c0 is horizontal sync and c1 vertical sync |
| align_off | output | 4 | Current slice bit offset, 0 to 9 |
| locked | output | 1 | Word alignment lock flag |

## Verification
The bench builds the block with SEARCH_CYCLES set to 40 and LOCK_RUN left at 16. With these values a skew of three bits forces seven slips, and a later skew change walks the offset through 9 and back to 0, all in a few hundred cycles. Lock loss after one search interval is also reached that quickly. The exact lock threshold of 16 is tested by showing 15 tokens, then 16.

// File: rtl/tmds_rx_pkg.sv
package tmds_rx_pkg;

    localparam int SYM_W  = 10;
    localparam int BYTE_W = 8;
    localparam int OFF_W  = $clog2(SYM_W);

    typedef logic [SYM_W-1:0]  sym_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Blanking tokens, indexed by {c1,c0}
    localparam sym_t TOKEN_00 = 10'b1101010100;
    localparam sym_t TOKEN_01 = 10'b0010101011;
    localparam sym_t TOKEN_10 = 10'b0101010100;
    localparam sym_t TOKEN_11 = 10'b1010101011;

    typedef struct packed {
        logic       hit;
        logic [1:0] code;
    } tok_t;

    function automatic tok_t classify(input sym_t s);
        tok_t t;
        t.hit  = 1'b1;
        t.code = 2'b00;
        case (s)
            TOKEN_00: t.code = 2'b00;
            TOKEN_01: t.code = 2'b01;
            TOKEN_10: t.code = 2'b10;
            TOKEN_11: t.code = 2'b11;
            default:  t.hit  = 1'b0;
        endcase
        return t;
    endfunction

    // Bit 9 undoes the balance inversion, bit 8 picks XOR (1) or XNOR (0)
    function automatic byte_t unchain(input sym_t s);
        byte_t v;
        byte_t r;
        v    = s[SYM_W-1] ? ~s[BYTE_W-1:0] : s[BYTE_W-1:0];
        r[0] = v[0];
        for (int k = 1; k < BYTE_W; k++) begin
            r[k] = s[BYTE_W] ? (v[k] ^ v[k-1]) : ~(v[k] ^ v[k-1]);
        end
        return r;
    endfunction

endpackage

// File: rtl/tmds_word_aligner.sv
module tmds_word_aligner
    import tmds_rx_pkg::*;
#(
    parameter int SEARCH_CYCLES = 1024,
    parameter int LOCK_RUN      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  sym_t             word_in,
    output sym_t             slice_out,
    output tok_t             tok_out,
    output logic [OFF_W-1:0] off_out,
    output logic             lock_out
);

    localparam int TMR_W = ($clog2(SEARCH_CYCLES) < 1) ? 1 : $clog2(SEARCH_CYCLES);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SEARCH_CYCLES - 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_RUN);
    localparam logic [OFF_W-1:0] OFF_MAX  = OFF_W'(SYM_W - 1);

    typedef struct packed {
        sym_t             prev;
        logic [OFF_W-1:0] off;
        logic [TMR_W-1:0] tmr;
        logic [RUN_W-1:0] run;
        logic             lock;
    } align_st_t;

    align_st_t st_d, st_q;
    logic [2*SYM_W-1:0] window;
    sym_t               slice;
    tok_t               tok;
    logic               hit;
    logic               expire;

    assign window = {word_in, st_q.prev};
    assign slice  = window[st_q.off +: SYM_W];
    assign tok    = classify(slice);
    assign hit    = tok.hit;
    assign expire = !hit && (st_q.tmr == TMR_LAST);

    always_comb begin
        st_d      = st_q;
        st_d.prev = word_in;
        if (hit) begin
            st_d.tmr = '0;
            if (st_q.run != RUN_FULL) st_d.run = st_q.run + 1'b1;
            if (st_q.run == RUN_LAST) st_d.lock = 1'b1;
        end else if (expire) begin
            st_d.tmr  = '0;
            st_d.run  = '0;
            st_d.lock = 1'b0;
            st_d.off  = (st_q.off == OFF_MAX) ? '0 : st_q.off + 1'b1;
        end else begin
            st_d.tmr = st_q.tmr + 1'b1;
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign slice_out = slice;
    assign tok_out   = tok;
    assign off_out   = st_q.off;
    assign lock_out  = st_q.lock;

    assert_offset_range_R5: assert property (@(posedge clk) disable iff (rst)
        st_q.off <= OFF_MAX);

    assert_slip_after_silence_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.off) |-> ($past(st_q.tmr) == TMR_LAST) && !$past(hit));

    assert_lock_needs_token_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.lock) |-> $past(hit));

    assert_lock_drop_on_expiry_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.lock) |-> ($past(st_q.tmr) == TMR_LAST));

endmodule

// File: rtl/tmds_symbol_unpack.sv
module tmds_symbol_unpack
    import tmds_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sym_t       sym_in,
    input  tok_t       tok_in,
    output byte_t      pix_out,
    output logic       de_out,
    output logic [1:0] ctl_out
);

    typedef struct packed {
        byte_t      pix;
        logic       de;
        logic [1:0] ctl;
    } unpack_st_t;

    unpack_st_t st_d, st_q;
    logic       tok_hit;
    logic [1:0] tok_code;

    assign tok_hit  = tok_in.hit;
    assign tok_code = tok_in.code;

    always_comb begin
        st_d = st_q;
        if (tok_hit) begin
            st_d.de  = 1'b0;
            st_d.ctl = tok_code;
            st_d.pix = '0;
        end else begin
            st_d.de  = 1'b1;
            st_d.pix = unchain(sym_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pix_out = st_q.pix;
    assign de_out  = st_q.de;
    assign ctl_out = st_q.ctl;

    assert_token_blanks_R1: assert property (@(posedge clk) disable iff (rst)
        tok_hit |=> !st_q.de && (st_q.ctl == $past(tok_code)));

    assert_ctl_held_R4: assert property (@(posedge clk) disable iff (rst)
        !tok_hit |=> st_q.de && $stable(st_q.ctl));

    assert_pix_zero_blank_R4: assert property (@(posedge clk) disable iff (rst)
        tok_hit |=> (st_q.pix == '0));

endmodule

// File: rtl/tmds_symbol_decoder.sv
module tmds_symbol_decoder
    import tmds_rx_pkg::*;
#(
    parameter int SEARCH_CYCLES = 1024,
    parameter int LOCK_RUN      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [9:0]       word_in,
    output logic [7:0]       pix_out,
    output logic             de_out,
    output logic [1:0]       ctl_out,
    output logic [OFF_W-1:0] align_off,
    output logic             locked
);

    sym_t slice;
    tok_t tok;

    tmds_word_aligner #(
        .SEARCH_CYCLES (SEARCH_CYCLES),
        .LOCK_RUN      (LOCK_RUN)
    ) u_align (
        .clk       (clk),
        .rst       (rst),
        .word_in   (word_in),
        .slice_out (slice),
        .tok_out   (tok),
        .off_out   (align_off),
        .lock_out  (locked)
    );

    tmds_symbol_unpack u_unpack (
        .clk     (clk),
        .rst     (rst),
        .sym_in  (slice),
        .tok_in  (tok),
        .pix_out (pix_out),
        .de_out  (de_out),
        .ctl_out (ctl_out)
    );

endmodule

// File: tb/tb_tmds_symbol_decoder.sv
module tb_tmds_symbol_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int SEARCH     = 40;
    localparam int RUN        = 16;

    localparam logic [9:0] TK0 = 10'b1101010100;
    localparam logic [9:0] TK1 = 10'b0010101011;
    localparam logic [9:0] TK2 = 10'b0101010100;
    localparam logic [9:0] TK3 = 10'b1010101011;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] word_in = '0;
    logic [7:0] pix_out;
    logic       de_out;
    logic [1:0] ctl_out;
    logic [3:0] align_off;
    logic       locked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit         check;
        bit         de;
        bit [1:0]   ctl;
        bit [7:0]   pix;
        string      req;
    } exp_t;

    exp_t sb[$];
    bit   last_ctl_valid;
    bit [1:0] last_ctl;

    tmds_symbol_decoder #(.SEARCH_CYCLES(SEARCH), .LOCK_RUN(RUN)) dut (
        .clk(clk), .rst(rst), .word_in(word_in), .pix_out(pix_out),
        .de_out(de_out), .ctl_out(ctl_out), .align_off(align_off), .locked(locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [9:0] token_of(input bit [1:0] c);
        case (c)
            2'b00: return TK0;
            2'b01: return TK1;
            2'b10: return TK2;
            default: return TK3;
        endcase
    endfunction

    function automatic bit is_token(input logic [9:0] s);
        return (s == TK0) || (s == TK1) || (s == TK2) || (s == TK3);
    endfunction

    // Forward coding: chain the byte, then optionally invert for balance
    function automatic logic [9:0] encode(input logic [7:0] d, input bit xr, input bit inv);
        logic [7:0] q;
        q[0] = d[0];
        for (int k = 1; k < 8; k++) q[k] = xr ? (q[k-1] ^ d[k]) : ~(q[k-1] ^ d[k]);
        return {inv, xr, inv ? ~q : q};
    endfunction

    function automatic logic [9:0] safe_encode(input logic [7:0] d, input bit xr, input bit inv);
        logic [9:0] s;
        s = encode(d, xr, inv);
        if (is_token(s)) s = encode(d, xr, ~inv);
        return s;
    endfunction

    // Word seen on the wire when the boundary is skewed by sk bits
    function automatic logic [9:0] skew_word(input logic [9:0] s, input int sk);
        logic [19:0] w;
        w = {s, s} >> sk;
        return w[9:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [9:0] w, input exp_t it);
        @(negedge clk);
        word_in = w;
        sb.push_back(it);
    endtask

    task automatic send_tok(input bit [1:0] c, input bit chk);
        exp_t it;
        it.check = chk; it.de = 1'b0; it.ctl = c; it.pix = 8'h00; it.req = "R1 R3 R4";
        last_ctl = c; last_ctl_valid = 1'b1;
        drive(token_of(c), it);
    endtask

    task automatic send_data(input logic [7:0] d, input bit xr, input bit inv, input bit chk);
        exp_t it;
        it.check = chk && last_ctl_valid; it.de = 1'b1; it.ctl = last_ctl; it.pix = d;
        it.req = "R2 R3 R4";
        drive(safe_encode(d, xr, inv), it);
    endtask

    task automatic send_raw(input logic [9:0] w);
        exp_t it;
        it.check = 1'b0; it.de = 1'b0; it.ctl = 2'b00; it.pix = 8'h00; it.req = "";
        drive(w, it);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        word_in = 10'h3A5;
        repeat (3) @(negedge clk);
        sb.delete();
        last_ctl_valid = 1'b0;
        // R9: reset state
        check("R9", {31'b0, de_out}, 32'd0, "de_out");
        check("R9", {30'b0, ctl_out}, 32'd0, "ctl_out");
        check("R9", {24'b0, pix_out}, 32'd0, "pix_out");
        check("R9", {28'b0, align_off}, 32'd0, "align_off");
        check("R9", {31'b0, locked}, 32'd0, "locked");
        rst = 1'b0;
    endtask

    // Scoreboard monitor: each item is due two edges after it was driven
    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() >= 2) begin
            exp_t it;
            it = sb.pop_front();
            if (it.check) begin
                n_checks++;
                if (de_out !== it.de || ctl_out !== it.ctl || pix_out !== it.pix) begin
                    n_fail++;
                    $display("FAIL %s: actual de=%0b ctl=%0d pix=%02h expected de=%0b ctl=%0d pix=%02h",
                             it.req, de_out, ctl_out, pix_out, it.de, it.ctl, it.pix);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        last_ctl_valid = 1'b0;
        last_ctl = 2'b00;
        do_reset();

        // R7: 15 tokens then a break must not lock; 16 in a row must
        repeat (10) send_tok(2'b00, 1'b0);
        send_data(8'h5A, 1'b1, 1'b0, 1'b0);
        repeat (15) send_tok(2'b00, 1'b0);
        send_data(8'h5A, 1'b1, 1'b0, 1'b0);
        send_data(8'h5A, 1'b1, 1'b0, 1'b0);
        check("R7", {31'b0, locked}, 32'd0, "locked after 15-token run");
        repeat (16) send_tok(2'b00, 1'b0);
        send_data(8'h5A, 1'b1, 1'b0, 1'b0);
        send_data(8'h5A, 1'b1, 1'b0, 1'b0);
        check("R7", {31'b0, locked}, 32'd1, "locked after 16-token run");

        // R1 R2 R3 R4: mixed blanking and video through the scoreboard
        send_data(8'h00, 1'b1, 1'b0, 1'b1);
        send_data(8'hFF, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 240; i++) begin
            if ((i % 12) < 3) send_tok(2'((i / 12) % 4), 1'b1);
            else send_data(8'((i * 37 + 11) ^ (i >> 3)), bit'((i >> 1) & 1), bit'(i & 1), 1'b1);
        end
        send_tok(2'b10, 1'b1);
        send_data(8'h81, 1'b0, 1'b0, 1'b1);
        send_data(8'h7E, 1'b1, 1'b1, 1'b1);
        send_tok(2'b10, 1'b1);
        send_tok(2'b10, 1'b1);
        check("R3", {31'b0, locked}, 32'd1, "lock held during video");

        // R8 R5: silence for a full interval drops lock and slips once
        repeat (SEARCH - 5) send_data(8'h3C, 1'b1, 1'b0, 1'b0);
        check("R8", {31'b0, locked}, 32'd1, "lock before interval ends");
        repeat (10) send_data(8'h3C, 1'b1, 1'b0, 1'b0);
        check("R8", {31'b0, locked}, 32'd0, "lock after silent interval");
        check("R5", {28'b0, align_off}, 32'd1, "offset after one expiry");
        check("R4", {30'b0, ctl_out}, 32'd2, "control held through video");

        // R9: reset from a non-zero offset with a non-zero control code
        do_reset();

        // R6 R5: a three-bit skew must settle at offset 7
        repeat (SEARCH * 8 + 40) send_raw(skew_word(TK3, 3));
        check("R6", {28'b0, align_off}, 32'd7, "offset for skew 3");
        check("R7", {31'b0, locked}, 32'd1, "lock for skew 3");
        check("R1", {30'b0, ctl_out}, 32'd3, "token code under skew");
        check("R1", {31'b0, de_out}, 32'd0, "de under skew tokens");
        repeat (6) send_raw(skew_word(encode(8'hC3, 1'b0, 1'b1), 3));
        check("R6", {31'b0, de_out}, 32'd1, "de for skewed data");
        check("R6", {24'b0, pix_out}, 32'hC3, "pixel for skewed data");

        // R5: moving back to no skew walks 7 -> 8 -> 9 -> 0
        repeat (SEARCH * 4 + 40) send_raw(TK3);
        check("R5", {28'b0, align_off}, 32'd0, "offset after wrap");
        check("R7", {31'b0, locked}, 32'd1, "relock after wrap");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule